// File: doc/BRIEF.md
# Parallel-Port Axis Register Slave with Streaming Pointer

This block is the register-access side of a four-axis position board that sits on a byte-wide, EPP-style parallel bus. The host first runs an address cycle. The upper nibble of that byte names a board, and the lower nibble names a register inside it. After that, each data cycle transfers one byte to or from the selected register. Every transferred byte moves the internal pointer forward by one. Because of this, a host that points at location 0 can collect all twelve count bytes with twelve back-to-back reads.

Reads return the following:
- the latched 24-bit axis counts, split into bytes, least significant byte first;
- a flag register with one index-sense bit per axis;
- a fixed identification byte.

Writes do three things:
- build a 24-bit preset value one byte at a time;
- set a control byte that carries the per-axis load requests and the index-mode selects;
- set a timer configuration byte.

The axis counters and the timer are separate blocks. They consume the outputs of this block.

All bus inputs are taken as synchronous to `clk`. A transfer starts on the first clock at which its strobe is seen high after being low.

Top module: `axis_port_regs`

## Requirements
- R1: After a synchronous reset, all of the following are zero: `epp_doe`, `epp_dout`, `asm_value`, `load_req`, `idx_sel`, `timer_sel`, `timer_master`, `soft_latch` and `sense_clr`. The board is also deselected.
- R2: An address cycle whose `epp_din[7:4]` equals `board_id` selects the board and loads `epp_din[3:0]` into the pointer. An address cycle with any other upper nibble deselects the board.
- R3: A read at pointer value `p` in the range 0 to 11 returns bits `8*(p mod 3)+7 : 8*(p mod 3)` of the count of axis `p/3`. Each axis takes 24 bits of `axis_counts`, with axis 0 in the lowest bits.
- R4: A read at pointer 12 returns `{4'b0000, index_sense}`, where bit k belongs to axis k. It also raises `sense_clr` for exactly one cycle, in the same cycle that `epp_doe` rises. Reads at any other address leave `sense_clr` low.
- R5: A read at pointer 15 returns 0x11. Reads at 13 and 14 return 0x00.
- R6: Each data cycle to a selected board advances the pointer by one, and the pointer wraps from 15 to 0. Between data cycles the pointer holds its value.
- R7: A write at pointer 0, 1 or 2 replaces the low, middle or high byte of `asm_value`. The other two bytes keep their values.
- R8: A write at pointer 3 sets `load_req` to data bits 7:4 and `idx_sel` to data bits 3:0. In both fields, bit k refers to axis k.
- R9: A write at pointer 4 sets `timer_sel` from bits 3:0, `timer_master` from bit 4 and `soft_latch` from bit 5. Bits 7:6 are dropped.
- R10: A write at pointers 5 to 15 changes none of the outputs. It still advances the pointer.
- R11: While the board is deselected, a data cycle leaves `epp_doe` low and changes none of the register outputs.
- R12: On a read, `epp_doe` rises one clock after the strobe edge, and `epp_dout` carries the byte while `epp_doe` is high. Both return to zero one clock after the data strobe falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_id | input | 4 | Fixed number of this board, compared with the address upper nibble |
| epp_din | input | 8 | Bus byte from the host |
| epp_write | input | 1 | 1 = host writes during the data cycle, 0 = host reads |
| addr_stb | input | 1 | Address strobe, active high |
| data_stb | input | 1 | Data strobe, active high |
| axis_counts | input | 96 | Latched counts; axis k in bits 24k+23:24k |
| index_sense | input | 4 | Index-sense flags, bit k for axis k |
| epp_dout | output | 8 | Read byte driven toward the bus |
| epp_doe | output | 1 | Output enable for `epp_dout` |
| asm_value | output | 24 | Assembled preset value |
| load_req | output | 4 | Per-axis load-position requests |
| idx_sel | output | 4 | Per-axis index-mode selects |
| timer_sel | output | 4 | Timer select field |
| timer_master | output | 1 | Timer master flag |
| soft_latch | output | 1 | Software latch request |
| sense_clr | output | 1 | One-cycle pulse asking the sense flags to clear |

## Verification
Every result passes through one register stage after the clock edge at which the strobe rise is sampled:
- The read byte, the output enable and the clear pulse are all valid from that edge onward.
- A written field is visible from that same edge onward.
- The output enable drops one edge after the strobe is seen low.

The bench drives all inputs on the falling clock edge and samples on the next falling edge. Each sample therefore sits half a period after the register it observes has updated. The enable release is checked one further cycle later. Each read is compared with the value expected from its position in the map, and the pointer is computed from the start address plus the number of bytes already moved.

// File: rtl/apr_pkg.sv
package apr_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Pick one byte out of a packed count word.
  function automatic byte_t pick_byte(input logic [31:0] word, input int idx);
    return byte_t'(word >> (BYTE_W * idx));
  endfunction
endpackage

// File: rtl/apr_strobe_edge.sv
module apr_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  output logic rise,
  output logic fall
);
  logic stb_q;

  always_ff @(posedge clk) begin
    if (rst) stb_q <= 1'b0;
    else     stb_q <= stb;
  end

  assign rise = stb & ~stb_q;
  assign fall = ~stb & stb_q;
endmodule

// File: rtl/apr_addr_ptr.sv
module apr_addr_ptr #(
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_evt,
  input  logic              data_evt,
  input  logic [7:0]        din,
  input  logic [SEL_W-1:0]  board_id,
  output logic              sel_q,
  output logic [ADDR_W-1:0] ptr_q
);
  logic hit;
  assign hit = (din[ADDR_W +: SEL_W] == board_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      ptr_q <= '0;
    end else if (addr_evt) begin
      sel_q <= hit;
      if (hit) ptr_q <= din[ADDR_W-1:0];
    end else if (data_evt && sel_q) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!addr_evt && !data_evt) |=> $stable(ptr_q)); // R6
  AST_PTR_DESEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sel_q && !addr_evt) |=> $stable(ptr_q)); // R11
endmodule

// File: rtl/apr_wr_regs.sv
module apr_wr_regs #(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 24,
  parameter int N_AXES  = 4,
  parameter int TMR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [7:0]        din,
  output logic [CNT_W-1:0]  asm_q,
  output logic [7:0]        ctrl_q,
  output logic [TMR_W-1:0]  tmr_q
);
  localparam int ASM_BYTES = CNT_W / 8;
  localparam int CTRL_ADDR = ASM_BYTES;
  localparam int TMR_ADDR  = ASM_BYTES + 1;

  genvar g;
  generate
    for (g = 0; g < ASM_BYTES; g++) begin : g_asm
      always_ff @(posedge clk) begin
        if (rst)                                     asm_q[8*g +: 8] <= '0;
        else if (wr_evt && ptr == ADDR_W'(g))        asm_q[8*g +: 8] <= din;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      tmr_q  <= '0;
    end else if (wr_evt) begin
      if (ptr == ADDR_W'(CTRL_ADDR)) ctrl_q <= din;
      if (ptr == ADDR_W'(TMR_ADDR))  tmr_q  <= din[TMR_W-1:0];
    end
  end

  AST_ASM_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(asm_q)); // R7
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(ctrl_q)); // R8
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_evt |=> $stable(tmr_q)); // R9
endmodule

// File: rtl/apr_rd_path.sv
module apr_rd_path
  import apr_pkg::*;
#(
  parameter int          ADDR_W = 4,
  parameter int          CNT_W  = 24,
  parameter int          N_AXES = 4,
  parameter logic [7:0]  ID_CODE = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_evt,
  input  logic                    end_evt,
  input  logic [ADDR_W-1:0]       ptr,
  input  logic [N_AXES*CNT_W-1:0] counts,
  input  logic [N_AXES-1:0]       sense,
  output logic [7:0]              dout_q,
  output logic                    doe_q,
  output logic                    clr_q
);
  localparam int BPA        = CNT_W / 8;
  localparam int SENSE_ADDR = N_AXES * BPA;
  localparam int ID_ADDR    = (1 << ADDR_W) - 1;

  byte_t rd_byte;

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < N_AXES; k++) begin
      for (int j = 0; j < BPA; j++) begin
        if (ptr == ADDR_W'(k * BPA + j))
          rd_byte = pick_byte(32'(counts[k*CNT_W +: CNT_W]), j);
      end
    end
    if (ptr == ADDR_W'(SENSE_ADDR)) rd_byte = byte_t'(sense);
    if (ptr == ADDR_W'(ID_ADDR))    rd_byte = ID_CODE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      doe_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= rd_evt && (ptr == ADDR_W'(SENSE_ADDR));
      if (rd_evt) begin
        dout_q <= rd_byte;
        doe_q  <= 1'b1;
      end else if (end_evt) begin
        dout_q <= '0;
        doe_q  <= 1'b0;
      end
    end
  end

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !doe_q |-> (dout_q == 8'h00)); // R12
  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q); // R4
endmodule

// File: rtl/axis_port_regs.sv
module axis_port_regs #(
  parameter int         N_AXES  = 4,
  parameter int         CNT_W   = 24,
  parameter int         ADDR_W  = 4,
  parameter int         SEL_W   = 4,
  parameter logic [7:0] ID_CODE = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [SEL_W-1:0]        board_id,
  input  logic [7:0]              epp_din,
  input  logic                    epp_write,
  input  logic                    addr_stb,
  input  logic                    data_stb,
  input  logic [N_AXES*CNT_W-1:0] axis_counts,
  input  logic [N_AXES-1:0]       index_sense,
  output logic [7:0]              epp_dout,
  output logic                    epp_doe,
  output logic [CNT_W-1:0]        asm_value,
  output logic [N_AXES-1:0]       load_req,
  output logic [N_AXES-1:0]       idx_sel,
  output logic [3:0]              timer_sel,
  output logic                    timer_master,
  output logic                    soft_latch,
  output logic                    sense_clr
);
  localparam int TMR_W = 6;

  logic              a_rise, a_fall, d_rise, d_fall;
  logic              addr_evt, data_evt, rd_evt, wr_evt, end_evt;
  logic              sel;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        ctrl;
  logic [TMR_W-1:0]  tmr;

  apr_strobe_edge u_aedge (.clk(clk), .rst(rst), .stb(addr_stb), .rise(a_rise), .fall(a_fall));
  apr_strobe_edge u_dedge (.clk(clk), .rst(rst), .stb(data_stb), .rise(d_rise), .fall(d_fall));

  // Address cycle wins if both strobes rise together.
  assign addr_evt = a_rise;
  assign data_evt = d_rise & ~a_rise;
  assign rd_evt   = data_evt & sel & ~epp_write;
  assign wr_evt   = data_evt & sel &  epp_write;
  assign end_evt  = d_fall | a_rise;

  apr_addr_ptr #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_ptr (
    .clk(clk), .rst(rst), .addr_evt(addr_evt), .data_evt(data_evt),
    .din(epp_din), .board_id(board_id), .sel_q(sel), .ptr_q(ptr)
  );

  apr_wr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_AXES(N_AXES), .TMR_W(TMR_W)) u_wr (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .ptr(ptr), .din(epp_din),
    .asm_q(asm_value), .ctrl_q(ctrl), .tmr_q(tmr)
  );

  apr_rd_path #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_AXES(N_AXES), .ID_CODE(ID_CODE)) u_rd (
    .clk(clk), .rst(rst), .rd_evt(rd_evt), .end_evt(end_evt), .ptr(ptr),
    .counts(axis_counts), .sense(index_sense),
    .dout_q(epp_dout), .doe_q(epp_doe), .clr_q(sense_clr)
  );

  assign idx_sel      = ctrl[N_AXES-1:0];
  assign load_req     = ctrl[4 +: N_AXES];
  assign timer_sel    = tmr[3:0];
  assign timer_master = tmr[4];
  assign soft_latch   = tmr[5];

  AST_DOE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    epp_doe |-> sel); // R11
  AST_CLR_WITH_DOE: assert property (@(posedge clk) disable iff (rst)
    sense_clr |-> epp_doe); // R4
  AST_DESEL_NO_CTRL: assert property (@(posedge clk) disable iff (rst)
    (!sel && !addr_evt) |=> $stable(ctrl)); // R11
endmodule

// File: tb/axis_port_regs_tb.sv
module axis_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  board_id = 4'h3;
  logic [7:0]  epp_din = '0;
  logic        epp_write = 1'b0;
  logic        addr_stb = 1'b0;
  logic        data_stb = 1'b0;
  logic [95:0] axis_counts;
  logic [3:0]  index_sense = 4'b1010;
  logic [7:0]  epp_dout;
  logic        epp_doe;
  logic [23:0] asm_value;
  logic [3:0]  load_req, idx_sel, timer_sel;
  logic        timer_master, soft_latch, sense_clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  axis_port_regs u_dut (
    .clk(clk), .rst(rst), .board_id(board_id), .epp_din(epp_din),
    .epp_write(epp_write), .addr_stb(addr_stb), .data_stb(data_stb),
    .axis_counts(axis_counts), .index_sense(index_sense),
    .epp_dout(epp_dout), .epp_doe(epp_doe), .asm_value(asm_value),
    .load_req(load_req), .idx_sel(idx_sel), .timer_sel(timer_sel),
    .timer_master(timer_master), .soft_latch(soft_latch), .sense_clr(sense_clr)
  );

  function automatic logic [23:0] cnt_of(input int k);
    return 24'((k + 1) * 24'h13579B + k * 24'h0F0F);
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < 12) return 8'(cnt_of(a / 3) >> (8 * (a % 3)));
    if (a == 12) return {4'b0, index_sense};
    if (a == 15) return 8'h11;
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic addr_cyc(input logic [7:0] b);
    @(negedge clk); epp_din = b; addr_stb = 1'b1;
    @(negedge clk); addr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_cyc(input logic [7:0] b);
    @(negedge clk); epp_din = b; epp_write = 1'b1; data_stb = 1'b1;
    @(negedge clk); data_stb = 1'b0;
    @(negedge clk); epp_write = 1'b0;
  endtask

  // Read one byte; checks data, enable and clear pulse against address a (-1 = deselected).
  task automatic rd_cyc(input int a, input string req);
    @(negedge clk); epp_write = 1'b0; data_stb = 1'b1;
    @(negedge clk);
    if (a < 0) begin
      chk("R11 doe", 32'(epp_doe), 0);
    end else begin
      chk({req, " data"}, 32'(epp_dout), 32'(exp_rd(a)));
      chk("R12 doe high", 32'(epp_doe), 1);
      chk("R4 clr", 32'(sense_clr), 32'(a == 12));
    end
    data_stb = 1'b0;
    @(negedge clk);
    chk("R12 doe low", 32'(epp_doe), 0);
    chk("R12 dout low", 32'(epp_dout), 0);
    chk("R4 clr low", 32'(sense_clr), 0);
  endtask

  task automatic chk_outs(input string req, input logic [23:0] a, input logic [7:0] c,
                          input logic [5:0] t);
    chk({req, " asm"}, 32'(asm_value), 32'(a));
    chk({req, " ctrl"}, 32'({load_req, idx_sel}), 32'(c));
    chk({req, " tmr"}, 32'({soft_latch, timer_master, timer_sel}), 32'(t));
  endtask

  initial begin
    axis_counts = '0;
    for (int k = 0; k < 4; k++) axis_counts[24*k +: 24] = cnt_of(k);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_outs("R1", 24'h0, 8'h0, 6'h0);
    chk("R1 doe", 32'(epp_doe), 0);
    chk("R1 clr", 32'(sense_clr), 0);
    // R1: deselected after reset, reads do not drive
    rd_cyc(-1, "R1");

    // R2/R3/R4/R5/R6: start at every address, three consecutive reads
    for (int s = 0; s < 16; s++) begin
      addr_cyc({board_id, 4'(s)});
      for (int n = 0; n < 3; n++) rd_cyc((s + n) % 16, "R3/R5/R6");
    end
    // R3/R6: full stream of 17 bytes from 0, wrapping to 0
    addr_cyc({board_id, 4'h0});
    for (int n = 0; n < 17; n++) rd_cyc(n % 16, "R3 R6 stream");

    // R7 R8 R9: write 0..4 in one burst
    addr_cyc({board_id, 4'h0});
    wr_cyc(8'hA1); chk_outs("R7 lo", 24'h0000A1, 8'h00, 6'h00);
    wr_cyc(8'hB2); chk_outs("R7 mid", 24'h00B2A1, 8'h00, 6'h00);
    wr_cyc(8'hC3); chk_outs("R7 hi", 24'hC3B2A1, 8'h00, 6'h00);
    wr_cyc(8'h5C); chk_outs("R8", 24'hC3B2A1, 8'h5C, 6'h00);
    wr_cyc(8'hFA); chk_outs("R9", 24'hC3B2A1, 8'h5C, 6'h3A);
    // R10: 5..15 ignored; pointer wraps to 0 and next write hits low byte
    for (int n = 5; n < 16; n++) begin
      wr_cyc(8'hFF);
      chk_outs("R10", 24'hC3B2A1, 8'h5C, 6'h3A);
    end
    wr_cyc(8'h07); chk_outs("R6 wrap", 24'hC3B207, 8'h5C, 6'h3A);
    // R7 mid byte alone
    addr_cyc({board_id, 4'h1});
    wr_cyc(8'h66); chk_outs("R7 mid only", 24'hC36607, 8'h5C, 6'h3A);

    // R2/R11: other board number deselects
    addr_cyc({4'h4, 4'h3});
    wr_cyc(8'h00); chk_outs("R11 wr", 24'hC36607, 8'h5C, 6'h3A);
    rd_cyc(-1, "R11");
    // R2: reselect and read ID
    addr_cyc({board_id, 4'hF});
    rd_cyc(15, "R2 R5");
    // R4 with a different flag pattern
    index_sense = 4'b0101;
    addr_cyc({board_id, 4'hC});
    rd_cyc(12, "R4");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule